// File: doc/BRIEF.md
# MDIO Management Bus Master

This block drives a two-wire PHY management bus from a small 32-bit register window. Software selects the framing style (the older 5-bit register format or the extended format with a separate address cycle), loads the PHY port and device or register number, and then starts a bus frame with a single register write. The block produces the management clock from the system clock through a programmable divider. It shifts the frame out MSB first and, on reads, releases the data line during turnaround and captures the PHY's reply into the data register.

Three writes start frames. Writing the data word starts a write frame. Writing the control word with its read bit set starts a read frame. In extended mode, writing the address word starts an address frame. While a frame runs, a busy flag is visible in the status word and in the top bit of the data word, and every register write is dropped. A read to which no PHY answers sets a read-error flag, and the data word then holds the all-ones value left by the pulled-up line. The register bus is plain: a write strobe with a word index, and read data that follows the index combinationally. The bus carries no stream, so no valid/ready handshake is used.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status word reads divider field 4, busy 0, read error 0 and extended mode 0. Control, data and address read 0. The clock output is low and the data output enable is low.
- R2: While a frame runs, the management clock toggles every (divider field + 1) system clocks and starts low. A frame of T bits keeps busy high for exactly 2·T·(divider+1) system clocks after the starting write.
- R3: In 5-bit mode, a data-word write (status word 12, bit 6 clear) sends 32 ones, then start 01, opcode 01, port (control bits 9:5), register (control bits 4:0), turnaround 10 and the 16-bit value. All fields go out MSB first.
- R4: In 5-bit mode, writing control (word 13) with bit 15 set sends start 01 and opcode 10. The master stops driving from the first turnaround bit to the end of the frame, and the 16 bits sampled afterwards appear in data bits 15:0.
- R5: In extended mode (status bit 6 set), writing the address word (word 15) sends start 00, opcode 00, port, device and turnaround 10, followed by the 16-bit address. In 5-bit mode the same write only stores the value and leaves busy low.
- R6: In extended mode, a data-word write sends opcode 01. A read request sends opcode 11, or opcode 10 when control bit 14 (post-increment) is also set. All use start 00.
- R7: With control bit 10 set, frames omit the 32-bit preamble and are 32 bits long.
- R8: If the line is not low in the second turnaround bit of a read, status bit 1 (read error) is set and the data word reads 0xFFFF from the idle-high line. The next read that sees a low bit there clears it.
- R9: Status bit 0 and data-word bit 31 read 1 exactly while a frame is in progress.
- R10: Any register write that arrives while busy is ignored: status, control and address keep their values.
- R11: With the byte-order input low, register data on the bus is byte-reversed relative to the field layout: the reset status word reads 0x00040000. With it high, the layout is native: 0x00000400.
- R12: The master's data output and its enable change only while the management clock is low, never during its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_little_endian | input | 1 | Static byte order: 1 native layout, 0 byte-reversed |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 4 | Word index in the window (12 status, 13 control, 14 data, 15 address) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_word, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value as seen on the pin |

## Verification
The assertions assume that the divider field stays constant while a frame runs, which holds because writes during busy are dropped. They also assume that the environment pulls the data line high whenever nobody drives it. The bench builds the line as a resolved wire with a pull-up and a responder that drives only from the second turnaround bit through the data bits of read frames. Frames are started only through the register window. Writes during busy are issued on purpose, to confirm that they are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [3:0] W_STAT = 4'd12;
  localparam logic [3:0] W_CTL  = 4'd13;
  localparam logic [3:0] W_DATA = 4'd14;
  localparam logic [3:0] W_ADDR = 4'd15;

  localparam int ST_BUSY   = 0;
  localparam int ST_RDERR  = 1;
  localparam int ST_EXT    = 6;
  localparam int ST_DIV_LO = 8;
  localparam int CT_NOPRE  = 10;
  localparam int CT_SCAN   = 11;
  localparam int CT_PINC   = 14;
  localparam int CT_READ   = 15;

  typedef enum logic [1:0] {FR_ADDR, FR_WRITE, FR_READ, FR_PINC} frame_kind_t;

  function automatic logic [31:0] swap_bytes(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] pack_frame(logic ext, frame_kind_t k,
                                             logic [4:0] port, logic [4:0] dev,
                                             logic [15:0] payload);
    logic [1:0] st, op, ta;
    st = ext ? 2'b00 : 2'b01;
    case (k)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      FR_READ:  op = ext ? 2'b11 : 2'b10;
      default:  op = 2'b10;
    endcase
    ta = (k == FR_READ || k == FR_PINC) ? 2'b11 : 2'b10;
    return {st, op, port, dev, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic hit;

  assign hit  = en && (cnt == div);
  assign rise = hit && !mdc;
  assign fall = hit && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= div));

  assert_mdc_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int PRE_LEN   = 32,
  parameter int FRAME_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 use_pre,
  input  logic                 is_read,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdc,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rd_err,
  output logic [15:0]          rd_data
);
  localparam int TOT      = PRE_LEN + FRAME_LEN;
  localparam int IDX_W    = $clog2(TOT + 1);
  localparam int TA_POS   = FRAME_LEN - 18;
  localparam int DATA_POS = TA_POS + 2;

  logic [TOT-1:0]   sr;
  logic [IDX_W-1:0] idx, off, last, pos;
  logic             pre_q, rd_q, in_body, released;

  assign off      = pre_q ? IDX_W'(PRE_LEN) : '0;
  assign last     = off + IDX_W'(FRAME_LEN - 1);
  assign in_body  = idx >= off;
  assign pos      = idx - off;
  assign released = rd_q && in_body && (pos >= IDX_W'(TA_POS));
  assign mdio_o   = sr[TOT-1];
  assign mdio_oe  = busy && !released;
  assign done     = busy && fall && (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      sr      <= '0;
      pre_q   <= 1'b0;
      rd_q    <= 1'b0;
      rd_err  <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      idx    <= '0;
      pre_q  <= use_pre;
      rd_q   <= is_read;
      rd_err <= 1'b0;
      sr     <= use_pre ? {{PRE_LEN{1'b1}}, frame_in} : {frame_in, {PRE_LEN{1'b0}}};
    end else if (busy) begin
      if (rise && released) begin
        if (pos == IDX_W'(TA_POS + 1)) rd_err <= mdio_i;
        if (pos >= IDX_W'(DATA_POS)) rd_data <= {rd_data[14:0], mdio_i};
      end
      if (fall) begin
        if (idx == last) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sr  <= {sr[TOT-2:0], 1'b0};
        end
      end
    end
  end

  assert_hold_while_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4,
  parameter int PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_little_endian,
  input  logic        reg_wr,
  input  logic [3:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = 32;

  logic [31:0] wr_nat, rd_nat;
  logic        busy, done, wr_ok, rise, fall, rd_err;
  logic [15:0] rd_data;

  logic             ext_q, nopre_q, scan_q, pinc_q, rdbit_q, rderr_q, rd_frame_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       dev_q, port_q;
  logic [15:0]      data_q, addr_q;

  logic             start, f_pre, f_read;
  frame_kind_t      kind;
  logic [4:0]       f_port, f_dev;
  logic [15:0]      payload;
  logic [31:0]      frame;
  logic             unused_bits;

  assign wr_nat      = cfg_little_endian ? reg_wdata : swap_bytes(reg_wdata);
  assign wr_ok       = reg_wr && !busy;
  assign unused_bits = ^{wr_nat[31:16], wr_nat[13:12]};

  always_comb begin
    start   = 1'b0;
    kind    = FR_WRITE;
    f_port  = port_q;
    f_dev   = dev_q;
    f_pre   = !nopre_q;
    payload = wr_nat[15:0];
    if (wr_ok && reg_word == W_ADDR && ext_q) begin
      start = 1'b1;
      kind  = FR_ADDR;
    end else if (wr_ok && reg_word == W_DATA) begin
      start = 1'b1;
    end else if (wr_ok && reg_word == W_CTL && wr_nat[CT_READ]) begin
      start   = 1'b1;
      kind    = (ext_q && wr_nat[CT_PINC]) ? FR_PINC : FR_READ;
      f_port  = wr_nat[9:5];
      f_dev   = wr_nat[4:0];
      f_pre   = !wr_nat[CT_NOPRE];
      payload = '1;
    end
  end

  assign f_read = (kind == FR_READ) || (kind == FR_PINC);
  assign frame  = pack_frame(ext_q, kind, f_port, f_dev, payload);

  mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .en(busy), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN), .FRAME_LEN(FRAME_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame),
    .use_pre(f_pre), .is_read(f_read), .rise(rise), .fall(fall),
    .mdc(mdc), .mdio_i(mdio_i), .busy(busy), .done(done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q      <= 1'b0;
      div_q      <= DIV_W'(DIV_RESET);
      dev_q      <= '0;
      port_q     <= '0;
      nopre_q    <= 1'b0;
      scan_q     <= 1'b0;
      pinc_q     <= 1'b0;
      rdbit_q    <= 1'b0;
      data_q     <= '0;
      addr_q     <= '0;
      rderr_q    <= 1'b0;
      rd_frame_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_word)
          W_STAT: begin
            ext_q <= wr_nat[ST_EXT];
            div_q <= wr_nat[ST_DIV_LO +: DIV_W];
          end
          W_CTL: begin
            dev_q   <= wr_nat[4:0];
            port_q  <= wr_nat[9:5];
            nopre_q <= wr_nat[CT_NOPRE];
            scan_q  <= wr_nat[CT_SCAN];
            pinc_q  <= wr_nat[CT_PINC];
            rdbit_q <= wr_nat[CT_READ];
          end
          W_DATA:  data_q <= wr_nat[15:0];
          W_ADDR:  addr_q <= wr_nat[15:0];
          default: ;
        endcase
      end
      if (start) begin
        rd_frame_q <= f_read;
        if (f_read) rderr_q <= 1'b0;
      end
      if (done && rd_frame_q) begin
        data_q  <= rd_data;
        rderr_q <= rd_err;
      end
    end
  end

  always_comb begin
    rd_nat = '0;
    case (reg_word)
      W_STAT: begin
        rd_nat[ST_BUSY]            = busy;
        rd_nat[ST_RDERR]           = rderr_q;
        rd_nat[ST_EXT]             = ext_q;
        rd_nat[ST_DIV_LO +: DIV_W] = div_q;
      end
      W_CTL: begin
        rd_nat[4:0]      = dev_q;
        rd_nat[9:5]      = port_q;
        rd_nat[CT_NOPRE] = nopre_q;
        rd_nat[CT_SCAN]  = scan_q;
        rd_nat[CT_PINC]  = pinc_q;
        rd_nat[CT_READ]  = rdbit_q;
      end
      W_DATA: begin
        rd_nat[15:0] = data_q;
        rd_nat[31]   = busy;
      end
      W_ADDR:  rd_nat[15:0] = addr_q;
      default: ;
    endcase
  end

  assign reg_rdata = cfg_little_endian ? rd_nat : swap_bytes(rd_nat);

  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> ($stable(div_q) && $stable(ext_q) && $stable(addr_q)
                          && $stable(port_q) && $stable(dev_q)));

  assert_rderr_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rderr_q) |-> $past(rd_frame_q));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] O_STAT = 4'd12, O_CTL = 4'd13, O_DATA = 4'd14, O_ADDR = 4'd15;

  logic clk = 1'b0, rst_n = 1'b0, cfg_little_endian = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_word = 4'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i, line;
  logic phy_oe = 1'b0, phy_o = 1'b1;

  int checks = 0, errors = 0, fcnt = 0;
  bit phy_respond = 0, phy_pre = 1;
  logic [15:0] phy_reply = '0;
  bit cap[$];
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_little_endian(cfg_little_endian),
    .reg_wr(reg_wr), .reg_word(reg_word), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  assign line   = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);
  assign mdio_i = line;

  always @(posedge mdc) cap.push_back(line);

  always @(negedge mdc) begin
    int base;
    fcnt = fcnt + 1;
    base = phy_pre ? 32 : 0;
    if (phy_respond && fcnt >= base + 15 && fcnt <= base + 31) begin
      phy_oe = 1'b1;
      phy_o  = (fcnt == base + 15) ? 1'b0 : phy_reply[base + 31 - fcnt];
    end else begin
      phy_oe = 1'b0;
    end
  end

  function automatic logic [31:0] bs(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] w, logic [31:0] v);
    @(negedge clk);
    reg_word  = w;
    reg_wdata = cfg_little_endian ? v : bs(v);
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] w, output logic [31:0] v);
    reg_word = w;
    #1;
    v = cfg_little_endian ? reg_rdata : bs(reg_rdata);
  endtask

  task automatic push_bits(logic [15:0] v, int w);
    for (int i = w - 1; i >= 0; i--) exp_q.push_back(v[i]);
  endtask

  task automatic expect_frame(bit pre, logic [1:0] st, logic [1:0] op, logic [4:0] port,
                              logic [4:0] dev, logic [1:0] ta, logic [15:0] d);
    exp_q.delete();
    if (pre) for (int i = 0; i < 32; i++) exp_q.push_back(1'b1);
    push_bits(16'(st), 2); push_bits(16'(op), 2);
    push_bits(16'(port), 5); push_bits(16'(dev), 5);
    push_bits(16'(ta), 2); push_bits(d, 16);
  endtask

  // Start a frame, then compare busy and mdc against the timing model on every clock.
  task automatic run_frame(string req, logic [3:0] w, logic [31:0] v, int div);
    int n, nbits, hi, bad, chg;
    logic [31:0] s;
    logic pm, po, poe;
    nbits = exp_q.size();
    n = 2 * nbits * (div + 1);
    hi = 0; bad = 0; chg = 0;
    cap.delete(); fcnt = 0;
    bus_wr(w, v);
    pm = 1'b0; po = mdio_o; poe = mdio_oe;
    for (int k = 0; k <= n; k++) begin
      bus_rd(O_STAT, s);
      if (s[0] !== (k < n)) bad++;
      if (k < n && mdc) hi++;
      if (mdc && pm && (mdio_oe !== poe || (mdio_oe && mdio_o !== po))) chg++;
      pm = mdc; po = mdio_o; poe = mdio_oe;
      @(negedge clk);
    end
    check({"R9 busy window ", req}, bad, 0);
    check({"R2 mdc high cycles ", req}, hi, nbits * (div + 1));
    check({"R12 change while mdc high ", req}, chg, 0);
    check({req, " bit count"}, cap.size(), exp_q.size());
    bad = 0;
    for (int i = 0; i < exp_q.size() && i < cap.size(); i++) if (cap[i] != exp_q[i]) bad++;
    check({req, " frame bits"}, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog R1..: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(O_STAT, v); check("R1 status", v, 32'h0000_0400);
    bus_rd(O_CTL, v);  check("R1 control", v, 0);
    bus_rd(O_DATA, v); check("R1 data", v, 0);
    bus_rd(O_ADDR, v); check("R1 address", v, 0);
    check("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 0);

    // R11 byte order
    reg_word = O_STAT; #1; check("R11 reversed raw", reg_rdata, 32'h0004_0000);
    cfg_little_endian = 1'b1; #1; check("R11 native raw", reg_rdata, 32'h0000_0400);
    bus_wr(O_STAT, 32'h0000_0100);
    cfg_little_endian = 1'b0; reg_word = O_STAT; #1;
    check("R11 native write seen reversed", reg_rdata, 32'h0001_0000);

    // R3 5-bit write
    bus_wr(O_CTL, 32'h0000_00A3);
    phy_pre = 1; phy_respond = 0;
    expect_frame(1, 2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hBEEF);
    run_frame("R3 write", O_DATA, 32'h0000_BEEF, 1);

    // R4 5-bit read
    phy_respond = 1; phy_reply = 16'h1357;
    expect_frame(1, 2'b01, 2'b10, 5'd5, 5'd3, 2'b10, 16'h1357);
    run_frame("R4 read", O_CTL, 32'h0000_80A3, 1);
    bus_rd(O_DATA, v); check("R4 data", v, 32'h0000_1357);
    bus_rd(O_STAT, v); check("R4 no error", v, 32'h0000_0100);
    phy_respond = 0;

    // R7 no preamble
    bus_wr(O_CTL, 32'h0000_04A3);
    expect_frame(0, 2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'h00FF);
    run_frame("R7 short write", O_DATA, 32'h0000_00FF, 1);

    // R5 address write in 5-bit mode stores only
    bus_wr(O_ADDR, 32'h0000_0044);
    bus_rd(O_STAT, v); check("R5 no frame in 5-bit mode", v, 32'h0000_0100);
    bus_rd(O_ADDR, v); check("R5 stored", v, 32'h0000_0044);

    // extended mode frames
    bus_wr(O_STAT, 32'h0000_0140);
    bus_wr(O_CTL, 32'h0000_0041);
    expect_frame(1, 2'b00, 2'b00, 5'd2, 5'd1, 2'b10, 16'h0A0B);
    run_frame("R5 address", O_ADDR, 32'h0000_0A0B, 1);
    expect_frame(1, 2'b00, 2'b01, 5'd2, 5'd1, 2'b10, 16'h5555);
    run_frame("R6 write", O_DATA, 32'h0000_5555, 1);
    phy_respond = 1; phy_reply = 16'hCAFE;
    expect_frame(1, 2'b00, 2'b11, 5'd2, 5'd1, 2'b10, 16'hCAFE);
    run_frame("R6 read", O_CTL, 32'h0000_8041, 1);
    bus_rd(O_DATA, v); check("R6 read data", v, 32'h0000_CAFE);
    phy_reply = 16'h0F0F;
    expect_frame(1, 2'b00, 2'b10, 5'd2, 5'd1, 2'b10, 16'h0F0F);
    run_frame("R6 post-inc read", O_CTL, 32'h0000_C041, 1);
    bus_rd(O_DATA, v); check("R6 post-inc data", v, 32'h0000_0F0F);

    // R8 read error and recovery
    phy_respond = 0;
    expect_frame(1, 2'b00, 2'b11, 5'd2, 5'd1, 2'b11, 16'hFFFF);
    run_frame("R8 no responder", O_CTL, 32'h0000_8041, 1);
    bus_rd(O_STAT, v); check("R8 error set", v, 32'h0000_0142);
    bus_rd(O_DATA, v); check("R8 all ones", v, 32'h0000_FFFF);
    phy_respond = 1; phy_reply = 16'h1234;
    expect_frame(1, 2'b00, 2'b11, 5'd2, 5'd1, 2'b10, 16'h1234);
    run_frame("R8 recovery read", O_CTL, 32'h0000_8041, 1);
    bus_rd(O_STAT, v); check("R8 error cleared", v, 32'h0000_0140);
    phy_respond = 0;

    // R2 slower divider, no preamble
    bus_wr(O_STAT, 32'h0000_0340);
    bus_wr(O_CTL, 32'h0000_0441);
    phy_pre = 0;
    expect_frame(0, 2'b00, 2'b01, 5'd2, 5'd1, 2'b10, 16'h00AA);
    run_frame("R2 divider 3", O_DATA, 32'h0000_00AA, 3);

    // R10 writes during busy dropped, R9 busy in data word
    bus_wr(O_DATA, 32'h0000_2222);
    bus_wr(O_STAT, 32'h0000_0100);
    bus_wr(O_ADDR, 32'h0000_7777);
    bus_rd(O_DATA, v); check("R9 data busy bit", v, 32'h8000_2222);
    for (int k = 0; k < 2000; k++) begin
      bus_rd(O_STAT, v);
      if (v[0] == 1'b0) break;
      @(negedge clk);
    end
    bus_rd(O_STAT, v); check("R10 status kept", v, 32'h0000_0340);
    bus_rd(O_ADDR, v); check("R10 address kept", v, 32'h0000_0A0B);
    bus_rd(O_DATA, v); check("R10 data idle", v, 32'h0000_2222);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule